// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block models the feedback divider of an integer-N synthesizer, together with the reference divider that sits beside it. Everything runs on one clock, `clk`. Each clock edge stands for one cycle of the oscillator input. A small counter inside the block acts as the prescaler, dividing by 11 or by 10. Each prescaler cycle steps a 9-bit main counter (programmed value M). A 4-bit swallow counter (programmed value A) keeps the prescaler at 11 for the first A prescaler cycles of every output period. The feedback pulse `fp` therefore repeats every 10·(M+1)+A clocks. When `pre_bypass` is set, the prescaler is skipped and the period becomes M+1 clocks.

The reference side takes `ref_in`, a one-clock strobe for each reference edge. It emits a comparison pulse `fc` once every R+1 strobes. When R is zero, every strobe passes to `fc`. The programming values are static inputs. A new value is picked up at the next terminal count of its counter. `load_now` forces the values in at once, and `pwr_dn` holds both dividers at their start state.

Top module: `fdiv_chain`

## Requirements
- R1: With `pre_bypass` low, the distance between successive `fp` pulses is 10·(`m_val`+1)+`a_val` clocks. The configuration must satisfy `m_val` ≥ 1 and `a_val` ≤ `m_val`+1. The bench uses M=3, A=2 (42 clocks) and M=1, A=0 (20 clocks).
- R2: In each period, `msel` is high for the first 11·A clocks, which are A prescaler cycles of 11. It is low for the rest of the period. With A = M+1, `msel` stays high for the whole period of 11·(M+1) clocks.
- R3: With `pre_bypass` high, the period is `m_val`+1 clocks, `a_val` has no effect and `msel` stays low.
- R4: A change to `m_val`, `a_val` or `pre_bypass` in the middle of a period leaves that period unchanged. The new values govern the period that starts at the next terminal count. A change to `r_val` likewise waits for the next reference terminal count.
- R5: `fc` goes high once every `r_val`+1 strobes of `ref_in`, in the clock after the completing strobe. With `r_val` = 0, every strobe gives an `fc` clock.
- R6: Each `fp` pulse is exactly one clock wide.
- R7: While `load_now` is high, `fp` stays low and both dividers reload from the inputs on every clock. The first `fp` appears N clocks after the last clock edge that saw `load_now` high.
- R8: While `pwr_dn` is high, `fp` and `fc` stay low. After release, the first `fp` comes N clocks after the last clock edge that saw `pwr_dn` high.
- R9: Reset (`rst_n` low) clears `fp`, `fc` and `msel` at once. Release passes through a two-stage synchronizer. The third clock edge after release loads the inputs, so the first `fp` appears N+3 clocks after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-side clock; each edge is one input cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| m_val | input | 9 | Main counter value M |
| a_val | input | 4 | Swallow counter value A |
| r_val | input | 6 | Reference counter value R |
| pre_bypass | input | 1 | High: skip the 10/11 stage, divide by M+1 |
| load_now | input | 1 | Immediate and continuous reload of programming |
| pwr_dn | input | 1 | Hold both dividers at their start state, outputs low |
| ref_in | input | 1 | One-clock strobe per reference edge |
| fp | output | 1 | Divided feedback pulse |
| fc | output | 1 | Divided reference (comparison) pulse |
| msel | output | 1 | Modulus select: high while the prescaler divides by 11 |

## Verification
`fp` is registered. It rises in the clock that follows the terminal clock of a period, so it is seen one edge after the count completes. `fc` likewise rises one edge after the strobe that finishes its count. `msel` is decoded from counter state and changes on the same edge that reloads or steps the swallow counter. After reset release the first load happens on the third edge. The bench's behavioural model is advanced on each rising edge, with inputs changed only on falling edges. Every output is compared with the model at the falling edge, half a period after the edge that produced it. Explicit interval counts are taken between falling edges that observe `fp` high, so the register delay cancels out of each period measurement.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // default field widths of the programming inputs
  localparam int unsigned MAIN_W_DEF = 9;
  localparam int unsigned SWAL_W_DEF = 4;
  localparam int unsigned REF_W_DEF  = 6;
  // low modulus of the dual-modulus stage (the high modulus is one more)
  localparam int unsigned PRE_LO_DEF = 10;
  // reset synchronizer depth
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/fdiv_rst_sync.sv
module fdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/fdiv_main_chain.sv
module fdiv_main_chain #(
  parameter int unsigned M_W    = 9,
  parameter int unsigned A_W    = 4,
  parameter int unsigned PRE_LO = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [M_W-1:0] m_i,
  input  logic [A_W-1:0] a_i,
  input  logic           byp_i,
  output logic           fp_o,
  output logic           msel_o,
  output logic           reload_o
);
  localparam int unsigned PC_W = $clog2(PRE_LO + 1);
  localparam logic [PC_W-1:0] TOP_SLOW = PC_W'(PRE_LO);      // 11 clocks
  localparam logic [PC_W-1:0] TOP_FAST = PC_W'(PRE_LO - 1);  // 10 clocks

  logic [PC_W-1:0] pre_q,  pre_d;
  logic [M_W-1:0]  main_q, main_d;
  logic [A_W-1:0]  swal_q, swal_d, swal_dec;
  logic            byp_q,  byp_d;
  logic            fp_q,   fp_d;
  logic            pre_tc, end_tc, reload, cnt_en;

  assign pre_tc   = byp_q | (pre_q == '0);
  assign end_tc   = pre_tc & (main_q == '0);
  assign reload   = load_i | end_tc;
  assign cnt_en   = reload | pre_tc;
  assign swal_dec = (swal_q != '0) ? (swal_q - A_W'(1)) : swal_q;

  always_comb begin
    pre_d  = pre_q;
    main_d = main_q;
    swal_d = swal_q;
    byp_d  = byp_q;
    if (reload) begin
      main_d = m_i;
      swal_d = a_i;
      byp_d  = byp_i;
      pre_d  = (a_i != '0) ? TOP_SLOW : TOP_FAST;
    end else if (pre_tc) begin
      main_d = main_q - M_W'(1);
      swal_d = swal_dec;
      pre_d  = (swal_dec != '0) ? TOP_SLOW : TOP_FAST;
    end else begin
      pre_d  = pre_q - PC_W'(1);
    end
    fp_d = end_tc & ~load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      fp_q  <= 1'b0;
    end else begin
      pre_q <= pre_d;
      fp_q  <= fp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      swal_q <= '0;
      byp_q  <= 1'b0;
    end else if (cnt_en) begin
      main_q <= main_d;
      swal_q <= swal_d;
      byp_q  <= byp_d;
    end
  end

  assign fp_o     = fp_q;
  assign msel_o   = (swal_q != '0) & ~byp_q;
  assign reload_o = reload;
endmodule

// File: rtl/fdiv_ref_div.sv
module fdiv_ref_div #(
  parameter int unsigned R_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [R_W-1:0] r_i,
  input  logic           strobe_i,
  output logic           fc_o
);
  logic [R_W-1:0] cnt_q, cnt_d;
  logic           fc_q,  fc_d;
  logic           cnt_en;

  assign cnt_en = load_i | strobe_i;

  always_comb begin
    cnt_d = cnt_q;
    fc_d  = 1'b0;
    if (load_i) begin
      cnt_d = r_i;
    end else if (strobe_i) begin
      if (cnt_q == '0) begin
        cnt_d = r_i;
        fc_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - R_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fc_q <= 1'b0;
    else        fc_q <= fc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fc_o = fc_q;
endmodule

// File: rtl/fdiv_chain.sv
module fdiv_chain
  import fdiv_pkg::*;
#(
  parameter int unsigned M_W    = MAIN_W_DEF,
  parameter int unsigned A_W    = SWAL_W_DEF,
  parameter int unsigned R_W    = REF_W_DEF,
  parameter int unsigned PRE_LO = PRE_LO_DEF,
  parameter int unsigned SYNC_N = SYNC_STAGES_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic [R_W-1:0] r_val,
  input  logic           pre_bypass,
  input  logic           load_now,
  input  logic           pwr_dn,
  input  logic           ref_in,
  output logic           fp,
  output logic           fc,
  output logic           msel
);
  logic core_rst_n;
  logic run_q;
  logic force_load;
  logic chain_reload;

  fdiv_rst_sync #(.STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  // first edge out of reset behaves as a load of the programming inputs
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) run_q <= 1'b0;
    else             run_q <= 1'b1;
  end

  assign force_load = ~run_q | load_now | pwr_dn;

  fdiv_main_chain #(.M_W(M_W), .A_W(A_W), .PRE_LO(PRE_LO)) u_main (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load_i   (force_load),
    .m_i      (m_val),
    .a_i      (a_val),
    .byp_i    (pre_bypass),
    .fp_o     (fp),
    .msel_o   (msel),
    .reload_o (chain_reload)
  );

  fdiv_ref_div #(.R_W(R_W)) u_ref (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load_i   (force_load),
    .r_i      (r_val),
    .strobe_i (ref_in),
    .fc_o     (fc)
  );
endmodule

// File: rtl/fdiv_chain_chk.sv
module fdiv_chain_chk (
  input logic clk,
  input logic rst_n,
  input logic fp,
  input logic fc,
  input logic msel,
  input logic ref_in,
  input logic load_now,
  input logic pwr_dn,
  input logic reload
);
  AST_FP_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);                                             // R6
  AST_FC_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fc |-> $past(ref_in));                                   // R5
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!fp && !fc));                                // R8
  AST_LOAD_NO_FP: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> !fp);                                       // R7
  AST_MSEL_RISE_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msel) |-> $past(reload));                          // R2
endmodule

bind fdiv_chain fdiv_chain_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fp       (fp),
  .fc       (fc),
  .msel     (msel),
  .ref_in   (ref_in),
  .load_now (load_now),
  .pwr_dn   (pwr_dn),
  .reload   (chain_reload)
);

// File: tb/fdiv_chain_bench.sv
module fdiv_chain_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic [5:0] r_val;
  logic       pre_bypass, load_now, pwr_dn, ref_in;
  logic       fp, fc, msel;

  always #10 clk = ~clk;

  fdiv_chain u_fdiv_chain (
    .clk(clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val), .r_val(r_val),
    .pre_bypass(pre_bypass), .load_now(load_now), .pwr_dn(pwr_dn),
    .ref_in(ref_in), .fp(fp), .fc(fc), .msel(msel)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R9";
  int    ref_mode = 0;
  int    rcyc = 0;
  int    wd = 0;
  bit    done = 1'b0;

  // behavioural reference model
  int sync_cnt, pos, mM, mA, rleft;
  bit mByp, mrun, e_fp, e_fc;

  function automatic int period_of(int m, int a, bit b);
    return b ? (m + 1) : (10 * (m + 1) + a);
  endfunction

  function automatic bit exp_msel();
    return mrun && !mByp && (pos < 11 * mA);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt = 0; mrun = 0; e_fp = 0; e_fc = 0;
      pos = 0; mM = 0; mA = 0; mByp = 0; rleft = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else if (!mrun || load_now || pwr_dn) begin
      mrun = 1; pos = 0; e_fp = 0; e_fc = 0;
      mM = int'(m_val); mA = int'(a_val); mByp = pre_bypass; rleft = int'(r_val);
    end else begin
      if (pos == period_of(mM, mA, mByp) - 1) begin
        e_fp = 1; pos = 0;
        mM = int'(m_val); mA = int'(a_val); mByp = pre_bypass;
      end else begin
        e_fp = 0; pos++;
      end
      e_fc = 0;
      if (ref_in) begin
        if (rleft == 0) begin e_fc = 1; rleft = int'(r_val); end
        else rleft--;
      end
    end
  end

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference strobe pattern, changed on falling edges
  always @(negedge clk) begin
    if (ref_mode == 1)      ref_in <= 1'b1;
    else if (ref_mode == 2) begin ref_in <= (rcyc % 3 == 0); rcyc++; end
    else                    ref_in <= 1'b0;
  end

  // per-clock comparison, half a period after the producing edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check_bit(fp, e_fp, phase);
      check_bit(fc, e_fc, "R5");
      check_bit(msel, exp_msel(), "R2");
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      finish_up();
    end
  end

  task automatic wait_fp();
    while (fp !== 1'b1) @(negedge clk);
  endtask

  task automatic measure(input int exp_n, input string tag);
    int n;
    @(negedge clk);
    wait_fp();
    @(negedge clk);
    n = 1;
    check_bit(fp, 1'b0, "R6");
    while (fp !== 1'b1) begin @(negedge clk); n++; end
    check_int(n, exp_n, tag);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; m_val = 9'd3; a_val = 4'd2; r_val = 6'd3;
    pre_bypass = 1'b0; load_now = 1'b0; pwr_dn = 1'b0; ref_in = 1'b0;
    repeat (3) @(negedge clk);
    check_bit(fp, 1'b0, "R9");
    check_bit(fc, 1'b0, "R9");
    check_bit(msel, 1'b0, "R9");
    ref_mode = 2;
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (fp !== 1'b1);
    check_int(n, 45, "R9");

    phase = "R1";
    measure(42, "R1");
    measure(42, "R1");

    phase = "R2";
    m_val = 9'd3; a_val = 4'd4;
    measure(44, "R2");
    m_val = 9'd1; a_val = 4'd0;
    measure(20, "R1");

    phase = "R3";
    pre_bypass = 1'b1; m_val = 9'd5; a_val = 4'd7;
    measure(6, "R3");
    measure(6, "R3");

    phase = "R4";
    pre_bypass = 1'b0; m_val = 9'd20; a_val = 4'd5;
    measure(215, "R4");
    wait_fp();
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    m_val = 9'd2; a_val = 4'd1;
    while (fp !== 1'b1) begin @(negedge clk); n++; end
    check_int(n, 215, "R4");
    measure(31, "R4");

    phase = "R7";
    m_val = 9'd20; a_val = 4'd5;
    measure(215, "R7");
    repeat (10) @(negedge clk);
    m_val = 9'd2; a_val = 4'd0; load_now = 1'b1;
    repeat (3) @(negedge clk);
    load_now = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (fp !== 1'b1);
    check_int(n, 30, "R7");

    phase = "R8";
    repeat (7) @(negedge clk);
    pwr_dn = 1'b1;
    n = 0;
    repeat (50) begin @(negedge clk); if (fp === 1'b1 || fc === 1'b1) n++; end
    check_int(n, 0, "R8");
    pwr_dn = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (fp !== 1'b1);
    check_int(n, 30, "R8");

    phase = "R5";
    r_val = 6'd0; ref_mode = 1;
    repeat (80) @(negedge clk);
    n = 0;
    repeat (30) begin @(negedge clk); if (fc === 1'b1) n++; end
    check_int(n, 30, "R5");
    r_val = 6'd4; ref_mode = 2;
    repeat (100) @(negedge clk);
    n = 0;
    repeat (150) begin @(negedge clk); if (fc === 1'b1) n++; end
    check_int(n, 10, "R5");

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule